// File: doc/BRIEF.md
# Oversampled Serial Receiver with Flag-Tagged Receive Queue

This block turns an asynchronous serial line into parallel characters. A free-running 16x sampling enable drives the receiver. After a falling edge the receiver confirms a genuine start bit at its midpoint. It then samples each data bit, the optional parity bit and the first stop bit at its centre, least significant bit first. Every finished character is tagged with three flags (parity error, framing error, break). It is then written into a receive queue. The queue holds sixteen entries in queue mode, or a single entry in holding-register mode.

The host reads the head of the queue at any time: data, its three flags and a data-ready indication. A one-cycle read pulse removes the head. An overrun flag reports that a character arrived while no space was left. That character is dropped, and the stored characters are not touched.

The receive state machine has six states. RX_IDLE waits for a low line. RX_START rechecks the line at mid start bit, and goes back to RX_IDLE when the line is high again (false start) or moves on to RX_DATA. RX_DATA collects the data bits and then goes to RX_PAR when parity is enabled, otherwise to RX_STOP. RX_PAR samples the parity bit and goes to RX_STOP. RX_STOP samples the stop bit and loads the character, then goes to RX_BRKWAIT on a break and to RX_IDLE otherwise. RX_BRKWAIT holds until the line is high, then returns to RX_IDLE.

Top module: `uart_rx_buf`

## Requirements
- R1: After reset, `data_ready` and `overrun` are 0.
- R2: A frame is a low start bit, the data bits least significant first, an optional parity bit and a high stop bit, each lasting 16 ticks. Each bit is sampled near its centre, and the character comes out on `rd_data` with start, parity and stop bits removed.
- R3: `cfg_wlen` selects 5, 6, 7 or 8 data bits (codes 0, 1, 2, 3), and the unused upper bits of `rd_data` read 0.
- R4: With `cfg_par_en`=1 a parity bit follows the data. `cfg_par_even`=1 selects even parity and 0 selects odd parity. `rd_perr` is 1 when the received parity does not match. With parity off, `rd_perr` is 0.
- R5: A low pulse that is high again at the mid-start recheck (8 ticks after the edge) produces no character.
- R6: `rd_ferr` is 1 when the stop-bit sample is low.
- R7: A line held low for a whole frame loads one character of value 0 with `rd_brk`=1 and `rd_ferr`=1. No further character is loaded until the line has returned high.
- R8: With `cfg_fifo_en`=1 the queue holds up to 16 characters, delivered in arrival order, and each keeps its own flags. `data_ready` is 1 while the queue is not empty, and a one-cycle `rd_en` removes the head.
- R9: With `cfg_fifo_en`=0 the buffer holds one character. A second character that arrives before a read sets `overrun`.
- R10: A character that completes while the buffer is full (and no read happens in that cycle) is discarded and sets `overrun`. The flag stays set until a cycle with `rd_en`=1.
- R11: While `data_ready`=1 and no read happens, the head data does not change, even when new characters arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sampling enable at 16 times the bit rate |
| rxd | input | 1 | Serial input, idle high |
| cfg_wlen | input | 2 | Word length code: 0 to 3 for 5 to 8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 for even parity, 0 for odd parity |
| cfg_fifo_en | input | 1 | 1 for the 16-entry queue, 0 for a single holding register |
| rd_en | input | 1 | Removes the head entry and clears overrun |
| rd_data | output | 8 | Head character |
| rd_perr | output | 1 | Parity error flag of the head character |
| rd_ferr | output | 1 | Framing error flag of the head character |
| rd_brk | output | 1 | Break flag of the head character |
| data_ready | output | 1 | Buffer not empty |
| overrun | output | 1 | A character was dropped for lack of space |

## Verification
The bound checker checks several rules on every cycle: the overrun flag holds until a read and clears after a read, a loaded character always raises data-ready, a second character in holding-register mode raises overrun, a break character also carries a framing error, and the head stays stable while it is not read. What only the bench scenarios can show is whether the right bits were assembled. That covers bit order, the word-length masking, the parity sense, the false-start rejection, the single zero character loaded per break, and the queue order across all sixteen entries. The bench sweeps every word length against every parity mode and compares each character with a value it computes itself.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_BRKWAIT
    } rx_state_e;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_char_t;

    localparam int CHAR_W = $bits(rx_char_t);
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd_s,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    output logic       push_vld,
    output rx_char_t   push_char
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);

    rx_state_e state, state_nx;
    logic [CW-1:0] cnt;
    logic [2:0]    bidx;
    logic [7:0]    shreg;
    logic          par_acc;
    logic          all_zero;
    logic          bit_end;
    logic          last_bit;
    logic          brk_now;

    assign bit_end  = tick && (cnt == LAST);
    assign last_bit = (bidx == (3'(cfg_wlen) + 3'd4));
    assign brk_now  = all_zero && !rxd_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:    if (tick && !rxd_s) state_nx = RX_START;
            RX_START:   if (tick && cnt == MID) state_nx = rxd_s ? RX_IDLE : RX_DATA;
            RX_DATA:    if (bit_end && last_bit) state_nx = cfg_par_en ? RX_PAR : RX_STOP;
            RX_PAR:     if (bit_end) state_nx = RX_STOP;
            RX_STOP:    if (bit_end) state_nx = brk_now ? RX_BRKWAIT : RX_IDLE;
            RX_BRKWAIT: if (rxd_s) state_nx = RX_IDLE;
            default:    state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            bidx      <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            all_zero  <= 1'b1;
            push_vld  <= 1'b0;
            push_char <= '0;
        end else begin
            push_vld <= 1'b0;
            if (tick) begin
                if (state_nx != state) cnt <= '0;
                else                   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
            unique case (state)
                RX_IDLE: begin
                    bidx     <= '0;
                    shreg    <= '0;
                    par_acc  <= 1'b0;
                    all_zero <= 1'b1;
                end
                RX_DATA: if (bit_end) begin
                    shreg[bidx] <= rxd_s;
                    par_acc     <= par_acc ^ rxd_s;
                    all_zero    <= all_zero & !rxd_s;
                    bidx        <= bidx + 3'd1;
                end
                RX_PAR: if (bit_end) begin
                    par_acc  <= par_acc ^ rxd_s;
                    all_zero <= all_zero & !rxd_s;
                end
                RX_STOP: if (bit_end) begin
                    push_vld       <= 1'b1;
                    push_char.data <= shreg;
                    push_char.ferr <= !rxd_s;
                    push_char.brk  <= brk_now;
                    push_char.perr <= cfg_par_en && (cfg_par_even ? par_acc : !par_acc);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fifo_en,
    input  logic         wr_vld,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         ovr
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   count;
    logic [AW:0]   cap;
    logic          pop, full, accept;

    assign cap       = fifo_en ? (AW+1)'(DEPTH) : (AW+1)'(1);
    assign not_empty = (count != '0);
    assign pop       = rd_en && not_empty;
    assign full      = (count >= cap);
    assign accept    = wr_vld && (!full || pop);
    assign head      = mem[rptr];

    always_ff @(posedge clk) begin
        if (accept) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovr   <= 1'b0;
        end else begin
            if (accept) wptr <= wptr + 1'b1;
            if (pop)    rptr <= rptr + 1'b1;
            count <= count + (AW+1)'(accept) - (AW+1)'(pop);
            if (wr_vld && !accept) ovr <= 1'b1;
            else if (rd_en)        ovr <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
    import uart_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_fifo_en,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_brk,
    output logic       data_ready,
    output logic       overrun
);
    logic [1:0] sync_q;
    logic       push_vld;
    rx_char_t   push_char;
    rx_char_t   head_char;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    uart_rx_deser #(.OVS(OVS)) u_deser (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .rxd_s       (sync_q[1]),
        .cfg_wlen    (cfg_wlen),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_even(cfg_par_even),
        .push_vld    (push_vld),
        .push_char   (push_char)
    );

    uart_rx_queue #(.DEPTH(DEPTH), .W(CHAR_W)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (cfg_fifo_en),
        .wr_vld   (push_vld),
        .wr_data  (push_char),
        .rd_en    (rd_en),
        .head     (head_char),
        .not_empty(data_ready),
        .ovr      (overrun)
    );

    assign rd_data = head_char.data;
    assign rd_perr = head_char.perr;
    assign rd_ferr = head_char.ferr;
    assign rd_brk  = head_char.brk;
endmodule

// File: rtl/uart_rx_buf_chk.sv
module uart_rx_buf_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic        cfg_fifo_en,
    input logic        data_ready,
    input logic        overrun,
    input logic [7:0]  rd_data,
    input logic        push_vld,
    input logic [10:0] push_word
);
    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !rd_en |=> overrun); // R10
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !push_vld |=> !overrun); // R10
    AST_READY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        push_vld |=> data_ready); // R8
    AST_HOLD_REG_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        push_vld && data_ready && !rd_en && !cfg_fifo_en |=> overrun); // R9
    AST_BREAK_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
        push_vld && push_word[10] |-> push_word[9]); // R7
    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready && !rd_en |=> $stable(rd_data)); // R11
endmodule

bind uart_rx_buf uart_rx_buf_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .cfg_fifo_en(cfg_fifo_en),
    .data_ready (data_ready),
    .overrun    (overrun),
    .rd_data    (rd_data),
    .push_vld   (push_vld),
    .push_word  (push_char)
);

// File: tb/uart_rx_buf_bench.sv
module uart_rx_buf_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_fifo_en = 1'b1;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_brk, data_ready, overrun;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_buf u_uart_rx_buf (
        .clk(clk), .rst_n(rst_n), .tick16(1'b1), .rxd(rxd),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_fifo_en(cfg_fifo_en), .rd_en(rd_en), .rd_data(rd_data),
        .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
        .data_ready(data_ready), .overrun(overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v);
        @(negedge clk) rxd = v;
        repeat (15) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int wl, input bit pe, input bit ev,
                        input bit bad_par, input bit stop_v);
        logic p;
        p = ^(d & 8'((1 << wl) - 1));
        p = ev ? p : ~p;
        if (bad_par) p = ~p;
        drive_bit(1'b0);
        for (int b = 0; b < wl; b++) drive_bit(d[b]);
        if (pe) drive_bit(p);
        drive_bit(stop_v);
        @(negedge clk) rxd = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic pop();
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", data_ready, 0);
        chk("R1 overrun", overrun, 0);

        // R2 R3 R4: sweep word length x parity mode x data, half with bad parity
        for (int wl = 5; wl <= 8; wl++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int i = 0; i < 8; i++) begin
                    logic [7:0] d;
                    bit pe, ev, bad;
                    d   = 8'(i * 53 + wl * 17 + pm * 5 + 1);
                    pe  = (pm != 0);
                    ev  = (pm == 2);
                    bad = pe && i[0];
                    cfg_wlen = 2'(wl - 5); cfg_par_en = pe; cfg_par_even = ev;
                    send(d, wl, pe, ev, bad, 1'b1);
                    chk("R2 ready", data_ready, 1);
                    chk("R3 data", rd_data, 32'(d & 8'((1 << wl) - 1)));
                    chk("R4 parity flag", rd_perr, bad);
                    chk("R6 framing flag", rd_ferr, 0);
                    chk("R7 break flag", rd_brk, 0);
                    pop();
                    chk("R8 empty after read", data_ready, 0);
                end
            end
        end

        // R5: short low pulses
        cfg_wlen = 2'd3; cfg_par_en = 1'b0;
        for (int w = 3; w <= 7; w += 2) begin
            @(negedge clk) rxd = 1'b0;
            repeat (w - 1) @(negedge clk);
            rxd = 1'b1;
            repeat (200) @(negedge clk);
            chk("R5 false start", data_ready, 0);
        end

        // R6: low stop bit
        send(8'h5C, 8, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 data", rd_data, 8'h5C);
        chk("R6 ferr", rd_ferr, 1);
        chk("R6 brk", rd_brk, 0);
        pop();
        chk("R6 single char", data_ready, 0);

        // R7: line held low for 30 bit times
        @(negedge clk) rxd = 1'b0;
        repeat (16 * 30) @(negedge clk);
        chk("R7 ready", data_ready, 1);
        chk("R7 data", rd_data, 0);
        chk("R7 brk", rd_brk, 1);
        chk("R7 ferr", rd_ferr, 1);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        pop();
        chk("R7 one char only", data_ready, 0);

        // R8 R10 R11: fill 16, then one more
        cfg_fifo_en = 1'b1;
        for (int k = 0; k < 16; k++) begin
            send(8'(8'hA0 + k), 8, 1'b0, 1'b0, 1'b0, 1'b1);
            chk("R11 head held", rd_data, 8'hA0);
        end
        chk("R10 no overrun at 16", overrun, 0);
        send(8'h5A, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10 overrun", overrun, 1);
        chk("R10 head kept", rd_data, 8'hA0);
        for (int k = 0; k < 16; k++) begin
            chk("R8 order", rd_data, 32'(8'hA0 + k));
            chk("R8 ready", data_ready, 1);
            pop();
            if (k == 0) chk("R10 clear on read", overrun, 0);
        end
        chk("R10 dropped char absent", data_ready, 0);

        // R9: holding-register mode
        cfg_fifo_en = 1'b0;
        send(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 first", rd_data, 8'h11);
        chk("R9 no overrun", overrun, 0);
        send(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 overrun", overrun, 1);
        chk("R9 head kept", rd_data, 8'h11);
        pop();
        chk("R9 single entry", data_ready, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule